// File: doc/BRIEF.md
# Pipelined Trilinear Grid Interpolator

This block turns a filtered, coarse three-axis grid back into a per-pixel filtered intensity. Each incoming pixel carries its column `x`, its row `y` and its own 8-bit intensity `I`. Together these name a point inside the grid. The spatial axes are scaled by a cell size of 2^S pixels and the intensity axis by a bin size of 2^R levels. The block reads the eight grid values at the corners of the cell that holds that point. It blends them first along intensity, then along x, then along y, with one pipeline stage for each axis. It returns one rounded 8-bit result per clock.

The grid values sit in a small local window memory, written one cell at a time through a write port. In a full system the upstream filtering stage fills this memory. Here the testbench loads it. The two scale exponents are sampled with each pixel, so consecutive pixels may use different cell sizes without draining the pipeline.

Top module: `grid_trilerp`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `outValid` is 0 and `outData` is 0.
- R2: A write with `gridWrEn`=1 stores `gridWrData` at cell (`gridWrCol`, `gridWrRow`, `gridWrBin`). A pixel that lies exactly on a grid node returns that node's stored value unchanged. Such a pixel has x = col·2^S, y = row·2^S and I = bin·2^R.
- R3: The cell index on each axis is the coordinate shifted right by its exponent. The blend weight is the coordinate's low S (or R) bits divided by 2^S (or 2^R). The output equals the trilinear blend of the eight corner values with these weights.
- R4: The blended value is rounded to the nearest integer, with an exact half rounded up, and saturated to 255.
- R5: A lower index past the last column, row or bin (GRID_W-1, GRID_H-1, GRID_B-1) is clamped to it. The upper neighbour index is also clamped, so a pixel beyond the grid edge returns the edge value.
- R6: `cfgSpatialLog2` values below 4 act as 4, so S is 4..7. `cfgRangeLog2` below 4 acts as 4 and above 6 acts as 6, so R is 4..6. Both are sampled with each pixel.
- R7: A pixel is accepted on every cycle that `inValid` is 1. Its result appears with `outValid`=1 exactly 4 clock edges after the edge that sampled it, in input order and with no gaps.
- R8: While `outValid` is 0, `outData` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSpatialLog2 | input | 3 | Spatial cell size exponent S |
| cfgRangeLog2 | input | 3 | Intensity bin size exponent R |
| inValid | input | 1 | Pixel present this cycle |
| inX | input | X_W | Pixel column |
| inY | input | Y_W | Pixel row |
| inI | input | 8 | Pixel intensity |
| gridWrEn | input | 1 | Write one grid cell |
| gridWrCol | input | COL_W | Grid column of write |
| gridWrRow | input | ROW_W | Grid row of write |
| gridWrBin | input | BIN_W | Grid intensity bin of write |
| gridWrData | input | 8 | Filtered grid value |
| outValid | output | 1 | Result present this cycle |
| outData | output | 8 | Filtered intensity |

## Verification
The hardest case to reach from the ports is a result that falls exactly halfway between two integers. Random grid contents almost never give an exact half after three weighted blends. The bench therefore rewrites two neighbouring grid cells with chosen values and sends a pixel on a node in x and y with an intensity fraction of exactly one half. The clamp corners are reached the same way: pixels with coordinates far past the loaded grid are sent at the largest and smallest exponents. A long back-to-back stream is then sent in which the exponents change on every pixel, so that the exponents sampled with each pixel must travel through the pipeline with it.

// File: rtl/grid_trilerp_pkg.sv
package grid_trilerp_pkg;
  // Per-stage load enables issued by the control to the datapath
  typedef struct packed {
    logic capIn;  // sample pixel, read eight corners
    logic adv1;   // intensity-axis blend
    logic adv2;   // x-axis blend
    logic adv3;   // y-axis blend, round, register output
  } stageStrobe_t;

  localparam int WGT_W = 7;  // weights are left-aligned to 7 fraction bits
endpackage

// File: rtl/grid_trilerp_ctrl.sv
module grid_trilerp_ctrl
  import grid_trilerp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strb,
  output logic         outValid
);
  logic [3:0] vld;

  always_ff @(posedge clk) begin
    if (!rstN) vld <= '0;
    else       vld <= {vld[2:0], inValid};
  end

  always_comb begin
    strb.capIn = inValid;
    strb.adv1  = vld[0];
    strb.adv2  = vld[1];
    strb.adv3  = vld[2];
    outValid   = vld[3];
  end

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [2:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd4) sinceRst <= sinceRst + 3'd1;
  end

  // R7: fixed four-edge latency from input sample to output valid
  a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd4) |-> (outValid == $past(inValid, 4)));

  // R1: nothing emerges right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd0) |-> !outValid);
endmodule

// File: rtl/grid_trilerp_datapath.sv
module grid_trilerp_datapath
  import grid_trilerp_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int Y_W    = 12,
  parameter int GRID_W = 8,
  parameter int GRID_H = 4,
  parameter int GRID_B = 16,
  localparam int COL_W = $clog2(GRID_W),
  localparam int ROW_W = $clog2(GRID_H),
  localparam int BIN_W = $clog2(GRID_B)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     strb,
  input  logic [2:0]       cfgSpatialLog2,
  input  logic [2:0]       cfgRangeLog2,
  input  logic [X_W-1:0]   inX,
  input  logic [Y_W-1:0]   inY,
  input  logic [7:0]       inI,
  input  logic             gridWrEn,
  input  logic [COL_W-1:0] gridWrCol,
  input  logic [ROW_W-1:0] gridWrRow,
  input  logic [BIN_W-1:0] gridWrBin,
  input  logic [7:0]       gridWrData,
  output logic [7:0]       outData
);
  localparam int CELLS  = GRID_W * GRID_H * GRID_B;
  localparam int ADDR_W = $clog2(CELLS);
  localparam logic [X_W-1:0]   X_LAST   = X_W'(GRID_W - 1);
  localparam logic [Y_W-1:0]   Y_LAST   = Y_W'(GRID_H - 1);
  localparam logic [7:0]       I_LAST   = 8'(GRID_B - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(GRID_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(GRID_H - 1);
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(GRID_B - 1);
  localparam logic [29:0]      HALF_LSB = 30'(1) << 20;

  function automatic logic [ADDR_W-1:0] cellAddr(input logic [ROW_W-1:0] r,
      input logic [COL_W-1:0] c, input logic [BIN_W-1:0] b);
    return ADDR_W'((int'(r) * GRID_W + int'(c)) * GRID_B + int'(b));
  endfunction

  // window memory of filtered grid values
  logic [7:0] gridMem [CELLS];
  always_ff @(posedge clk) begin
    if (gridWrEn) gridMem[cellAddr(gridWrRow, gridWrCol, gridWrBin)] <= gridWrData;
  end

  // ---- coordinate split: cell index and weight ----
  logic [2:0]       spLog, rgLog;
  logic [X_W-1:0]   xCell, xMask;
  logic [Y_W-1:0]   yCell, yMask;
  logic [7:0]       iCell, iMask;
  logic [COL_W-1:0] colLo, colHi;
  logic [ROW_W-1:0] rowLo, rowHi;
  logic [BIN_W-1:0] binLo, binHi;
  logic [WGT_W-1:0] fX, fY, fI;

  always_comb begin
    spLog = (cfgSpatialLog2 < 3'd4) ? 3'd4 : cfgSpatialLog2;
    rgLog = (cfgRangeLog2 < 3'd4) ? 3'd4 : ((cfgRangeLog2 > 3'd6) ? 3'd6 : cfgRangeLog2);
    xCell = inX >> spLog;
    yCell = inY >> spLog;
    iCell = inI >> rgLog;
    xMask = (X_W'(1) << spLog) - X_W'(1);
    yMask = (Y_W'(1) << spLog) - Y_W'(1);
    iMask = (8'd1 << rgLog) - 8'd1;
    colLo = (xCell >= X_LAST) ? COL_LAST : xCell[COL_W-1:0];
    colHi = (xCell >= X_LAST) ? COL_LAST : xCell[COL_W-1:0] + COL_W'(1);
    rowLo = (yCell >= Y_LAST) ? ROW_LAST : yCell[ROW_W-1:0];
    rowHi = (yCell >= Y_LAST) ? ROW_LAST : yCell[ROW_W-1:0] + ROW_W'(1);
    binLo = (iCell >= I_LAST) ? BIN_LAST : iCell[BIN_W-1:0];
    binHi = (iCell >= I_LAST) ? BIN_LAST : iCell[BIN_W-1:0] + BIN_W'(1);
    fX = WGT_W'((inX & xMask) << (3'd7 - spLog));
    fY = WGT_W'((inY & yMask) << (3'd7 - spLog));
    fI = WGT_W'((inI & iMask) << (3'd7 - rgLog));
  end

  // corner c: bit0 selects upper bin, bit1 upper column, bit2 upper row
  logic [ADDR_W-1:0] rdAddr [8];
  for (genvar c = 0; c < 8; c++) begin : g_corner
    localparam bit BIN_HI = (c % 2) == 1;
    localparam bit COL_HI = ((c / 2) % 2) == 1;
    localparam bit ROW_HI = (c / 4) == 1;
    assign rdAddr[c] = cellAddr(ROW_HI ? rowHi : rowLo,
                                COL_HI ? colHi : colLo,
                                BIN_HI ? binHi : binLo);
  end

  // ---- stage registers ----
  logic [7:0]       cornerVal [8];
  logic [WGT_W-1:0] aFI, aFX, aFY, s1FX, s1FY, s2FY;
  logic [15:0]      s1Val [4];
  logic [22:0]      s2Val [2];
  logic [15:0]      s1Next [4];
  logic [22:0]      s2Next [2];
  logic [29:0]      s3Sum, s3Round;
  logic [7:0]       outNext;

  always_comb begin
    for (int j = 0; j < 4; j++)
      s1Next[j] = 16'(cornerVal[2*j]) * 16'(8'd128 - {1'b0, aFI})
                + 16'(cornerVal[2*j+1]) * 16'(aFI);
    for (int k = 0; k < 2; k++)
      s2Next[k] = 23'(s1Val[2*k]) * 23'(8'd128 - {1'b0, s1FX})
                + 23'(s1Val[2*k+1]) * 23'(s1FX);
    s3Sum   = 30'(s2Val[0]) * 30'(8'd128 - {1'b0, s2FY}) + 30'(s2Val[1]) * 30'(s2FY);
    s3Round = (s3Sum + HALF_LSB) >> 21;
    outNext = (s3Round > 30'd255) ? 8'd255 : s3Round[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 8; c++) cornerVal[c] <= '0;
      for (int j = 0; j < 4; j++) s1Val[j] <= '0;
      for (int k = 0; k < 2; k++) s2Val[k] <= '0;
      {aFI, aFX, aFY, s1FX, s1FY, s2FY} <= '0;
      outData <= '0;
    end else begin
      if (strb.capIn) begin
        for (int c = 0; c < 8; c++) cornerVal[c] <= gridMem[rdAddr[c]];
        aFI <= fI; aFX <= fX; aFY <= fY;
      end
      if (strb.adv1) begin
        for (int j = 0; j < 4; j++) s1Val[j] <= s1Next[j];
        s1FX <= aFX; s1FY <= aFY;
      end
      if (strb.adv2) begin
        for (int k = 0; k < 2; k++) s2Val[k] <= s2Next[k];
        s2FY <= s1FY;
      end
      if (strb.adv3) outData <= outNext;
    end
  end

  // R8: output register only moves when the last stage advances
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv3 |=> $stable(outData));

  // R3: a convex blend along intensity never exceeds 255 at scale 128
  a_r3_stage1_convex: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv1 |=> (s1Val[0] <= 16'd32640 && s1Val[1] <= 16'd32640 &&
                   s1Val[2] <= 16'd32640 && s1Val[3] <= 16'd32640));

  // R3: second stage stays convex at scale 2^14
  a_r3_stage2_convex: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv2 |=> (s2Val[0] <= 23'd4177920 && s2Val[1] <= 23'd4177920));

  // R5: clamped neighbour indices stay inside the grid and at most one apart
  a_r5_clamped_span: assert property (@(posedge clk) disable iff (!rstN)
    strb.capIn |-> (colHi >= colLo && colHi - colLo <= COL_W'(1) && colHi <= COL_LAST &&
                    rowHi >= rowLo && rowHi - rowLo <= ROW_W'(1) && rowHi <= ROW_LAST &&
                    binHi >= binLo && binHi - binLo <= BIN_W'(1) && binHi <= BIN_LAST));
endmodule

// File: rtl/grid_trilerp.sv
module grid_trilerp
  import grid_trilerp_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int Y_W    = 12,
  parameter int GRID_W = 8,
  parameter int GRID_H = 4,
  parameter int GRID_B = 16,
  localparam int COL_W = $clog2(GRID_W),
  localparam int ROW_W = $clog2(GRID_H),
  localparam int BIN_W = $clog2(GRID_B)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgSpatialLog2,
  input  logic [2:0]       cfgRangeLog2,
  input  logic             inValid,
  input  logic [X_W-1:0]   inX,
  input  logic [Y_W-1:0]   inY,
  input  logic [7:0]       inI,
  input  logic             gridWrEn,
  input  logic [COL_W-1:0] gridWrCol,
  input  logic [ROW_W-1:0] gridWrRow,
  input  logic [BIN_W-1:0] gridWrBin,
  input  logic [7:0]       gridWrData,
  output logic             outValid,
  output logic [7:0]       outData
);
  stageStrobe_t strb;

  grid_trilerp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  grid_trilerp_datapath #(
    .X_W(X_W), .Y_W(Y_W), .GRID_W(GRID_W), .GRID_H(GRID_H), .GRID_B(GRID_B)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .cfgSpatialLog2 (cfgSpatialLog2),
    .cfgRangeLog2   (cfgRangeLog2),
    .inX            (inX),
    .inY            (inY),
    .inI            (inI),
    .gridWrEn       (gridWrEn),
    .gridWrCol      (gridWrCol),
    .gridWrRow      (gridWrRow),
    .gridWrBin      (gridWrBin),
    .gridWrData     (gridWrData),
    .outData        (outData)
  );
endmodule

// File: tb/grid_trilerp_test.sv
module grid_trilerp_test;
  localparam int GW = 8, GH = 4, GB = 16;

  logic clk = 0, rstN = 0;
  logic [2:0] cfgSpatialLog2 = 3'd4, cfgRangeLog2 = 3'd4;
  logic inValid = 0;
  logic [11:0] inX = 0, inY = 0;
  logic [7:0] inI = 0;
  logic gridWrEn = 0;
  logic [2:0] gridWrCol = 0;
  logic [1:0] gridWrRow = 0;
  logic [3:0] gridWrBin = 0;
  logic [7:0] gridWrData = 0;
  logic outValid;
  logic [7:0] outData;

  always #10 clk = ~clk;  // 50 MHz

  grid_trilerp uut (.*);

  typedef struct { int expv; int issue; string tag; } item_t;
  item_t sbq[$];
  int gm [GW][GH][GB];
  int checks = 0, failures = 0, cyc = 0, sent = 0, seen = 0, lastOut = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int clampi(int v, int top);
    return (v > top) ? top : v;
  endfunction

  // reference from R3..R6
  function automatic int model(int x, int y, int i, int sp, int rg);
    int s, r, cx, cy, ci, wx, wy, wi;
    longint acc;
    s = (sp < 4) ? 4 : sp;
    r = (rg < 4) ? 4 : ((rg > 6) ? 6 : rg);
    cx = x >> s; cy = y >> s; ci = i >> r;
    wx = (x % (1 << s)) * (128 >> s);
    wy = (y % (1 << s)) * (128 >> s);
    wi = (i % (1 << r)) * (128 >> r);
    acc = 0;
    for (int dy = 0; dy < 2; dy++)
      for (int dx = 0; dx < 2; dx++)
        for (int di = 0; di < 2; di++)
          acc += longint'(gm[clampi(cx + dx, GW-1)][clampi(cy + dy, GH-1)][clampi(ci + di, GB-1)])
               * (dx ? wx : 128 - wx) * (dy ? wy : 128 - wy) * (di ? wi : 128 - wi);
    acc = (acc + (longint'(1) << 20)) >>> 21;
    return (acc > 255) ? 255 : int'(acc);
  endfunction

  task automatic writeCell(int c, int r, int b, int v);
    @(negedge clk);
    gridWrEn = 1; gridWrCol = 3'(c); gridWrRow = 2'(r); gridWrBin = 4'(b); gridWrData = 8'(v);
    gm[c][r][b] = v;
    @(negedge clk);
    gridWrEn = 0;
  endtask

  // driver: one pixel on the next cycle, expected value pushed to the scoreboard
  task automatic sendPx(int x, int y, int i, int sp, int rg, int expv, string tag);
    @(negedge clk);
    inValid = 1; inX = 12'(x); inY = 12'(y); inI = 8'(i);
    cfgSpatialLog2 = 3'(sp); cfgRangeLog2 = 3'(rg);
    sbq.push_back('{expv, cyc, tag});
    sent++;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbq.size() == 0) check(0, "R7 output with empty scoreboard", outData, -1);
      else begin
        item_t it;
        it = sbq.pop_front();
        check(int'(outData) == it.expv, it.tag, outData, it.expv);
        check(cyc - it.issue == 4, "R7 latency", cyc - it.issue, 4);
      end
      seen++;
      lastOut = outData;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 0, "R1 outValid in reset", outValid, 0);
    check(outData == 0, "R1 outData in reset", outData, 0);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0, "R1 outValid after reset", outValid, 0);
    check(outData == 0, "R1 outData after reset", outData, 0);

    for (int c = 0; c < GW; c++)
      for (int r = 0; r < GH; r++)
        for (int b = 0; b < GB; b++)
          writeCell(c, r, b, (c * 29 + r * 71 + b * 13 + ((c * b) % 7) * 17) % 256);

    // R2: grid nodes return stored values exactly
    sendPx(0, 0, 0, 5, 4, gm[0][0][0], "R2 node 0,0,0");
    sendPx(3 << 5, 2 << 5, 9 << 4, 5, 4, gm[3][2][9], "R2 node 3,2,9");
    sendPx(6 << 6, 1 << 6, 3 << 5, 6, 5, gm[6][1][3], "R2 node 6,1,3");
    idle(6);

    // R4: exact half rounds up, quarter rounds to nearest
    writeCell(0, 0, 0, 10);
    writeCell(0, 0, 1, 11);
    sendPx(0, 0, 8, 4, 4, 11, "R4 10.5 rounds up");
    sendPx(0, 0, 4, 4, 4, 10, "R4 10.25 rounds down");
    sendPx(0, 0, 12, 4, 4, 11, "R4 10.75 rounds up");
    idle(6);

    // R5: beyond the grid edge
    sendPx(4095, 4095, 255, 4, 4, gm[GW-1][GH-1][GB-1], "R5 far corner clamp");
    sendPx(4095, 0, 0, 7, 6, gm[GW-1][0][0], "R5 column clamp");
    sendPx(0, 4095, 240, 4, 4, gm[0][GH-1][GB-1], "R5 row and bin clamp");
    sendPx(1000, 200, 250, 7, 4, model(1000, 200, 250, 7, 4), "R5 partial clamp");
    idle(6);

    // R6: out-of-range exponents
    sendPx(37, 21, 77, 1, 4, model(37, 21, 77, 4, 4), "R6 spatial below 4");
    sendPx(37, 21, 77, 4, 0, model(37, 21, 77, 4, 4), "R6 range below 4");
    sendPx(37, 21, 200, 4, 7, model(37, 21, 200, 4, 6), "R6 range above 6");
    idle(6);

    // R3/R7: back-to-back stream, exponents change every pixel
    for (int n = 0; n < 300; n++) begin
      int x, y, i, sp, rg;
      x = $urandom_range(0, 1100); y = $urandom_range(0, 560);
      i = $urandom_range(0, 255);
      sp = $urandom_range(4, 7); rg = $urandom_range(4, 6);
      sendPx(x, y, i, sp, rg, model(x, y, i, sp, rg), "R3 stream");
    end
    idle(8);

    // R8: output holds while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(outValid == 0 && int'(outData) == lastOut, "R8 hold", outData, lastOut);
    end

    check(seen == sent, "R7 result count", seen, sent);
    check(sbq.size() == 0, "R7 scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule